// File: doc/BRIEF.md
# Real-Time Clock Bus Interface and Control Registers

This block sits between a narrow processor bus and the timekeeping core of a real-time clock. It decodes a 16-location space of 4-bit registers. Locations 13 and 15 are control registers held inside the block. Every other location belongs to the external counter chain or to the pulse generator. The block forwards writes to those locations on a simple strobe port and returns their read data on the bus.

The address may be latched by an address-latch strobe, or passed straight through when that strobe is tied high. Writes take effect on the rising edge of the write strobe. Read data is enabled only when both chip selects are active, the read strobe is low and the write strobe is high.

The block also runs the timing controls:
- the hold/busy handshake, which defers a one-second tick while software reads or writes the time;
- a self-clearing 30-second adjust;
- the divider reset, stop, 12/24-hour and test bits.

From these it drives the prescaler controls and the seconds-advance enable.

Top module: `rtc_bus_ctl`

## Requirements
- R1: While `ale`=1 and `cs0_n`=0, the address pins pass straight through to the decode. After `ale` falls, the last address seen with `ale`=1 is used, even if the address pins change.
- R2: A write is committed on the first clock after `wr_n` rises while `cs1`=1 and `cs0_n`=0. Locations other than 13 and 15 produce a one-cycle `ext_we` with that address and data. A write attempted with `cs1`=0 does nothing.
- R3: `data_oe`=1 only when `cs1`=1, `cs0_n`=0, `rd_n`=0 and `wr_n`=1, so a read with `wr_n`=0 is suppressed. Whenever `data_oe`=0, `data_out` is 0. Reads of locations other than 13 and 15 return `ext_rdata`.
- R4: Location 15 holds four bits: bit0 = divider reset, bit1 = stop, bit2 = 24-hour mode (1 = 24-hour), bit3 = test. All four read back. Bit2 is loaded from a write only if the reset bit was already 1 before that write.
- R5: While `cs1`=0, the hold bit and the reset bit are forced to 0.
- R6: While hold (location 13 bit0) is 1, a tick does not raise `sec_inc`. One deferred `sec_inc` pulse follows on the clock after hold is cleared. With hold at 0, a tick gives `sec_inc` on the next clock.
- R7: Location 13 bit1 (busy) reads 1 for BUSY_CYCLES clocks after a tick, but only while hold is 1. It reads 0 whenever hold is 0. A write to this bit has no effect.
- R8: Writing location 13 with bit3=1 raises `adj_zero` for one cycle. It also raises `adj_carry` in the same cycle when `sec10` ≥ 3. Bit3 then reads 1 for ADJ_CYCLES clocks and returns to 0 by itself.
- R9: `div_clr` = reset bit and not test; `div_run` = 0 when stop is 1 and test is 0. Outside test mode, `sec_tick` advances the seconds only when reset and stop are both 0. In test mode only `fast_tick` advances them, and reset and stop do not block it.
- R10: Location 13 bit2 reads the `irq_flag` input. Writing location 13 with bit2=0 pulses `flag_clr` for one cycle; writing it with bit2=1 does not.
- R11: After reset, all control bits are 0, `div_run`=1, and `sec_inc`, `ext_we` and `data_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale | input | 1 | Address latch enable (tie high for pass-through) |
| cs0_n | input | 1 | Active-low chip select |
| cs1 | input | 1 | Active-high chip select (power-good) |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 4 | Register address |
| data_in | input | 4 | Write data |
| data_out | output | 4 | Read data, 0 when not enabled |
| data_oe | output | 1 | Read data output enable |
| sec_tick | input | 1 | One-second carry pulse from the prescaler |
| fast_tick | input | 1 | Fast divider pulse used in test mode |
| irq_flag | input | 1 | Interrupt flag level from the pulse generator |
| sec10 | input | 3 | Current tens-of-seconds digit |
| ext_rdata | input | 4 | Read data from external locations |
| ext_we | output | 1 | One-cycle write strobe to external locations |
| ext_addr | output | 4 | Address for the external write |
| ext_wdata | output | 4 | Data for the external write |
| flag_clr | output | 1 | One-cycle request to clear the interrupt flag |
| sec_inc | output | 1 | Advance the seconds counter by one |
| adj_zero | output | 1 | Zero the seconds (30-second adjust) |
| adj_carry | output | 1 | Carry one into the minutes (30-second adjust) |
| div_clr | output | 1 | Hold the sub-second divider in reset |
| div_run | output | 1 | Allow carries into the divider |
| mode_24h | output | 1 | 1 selects 24-hour mode |

## Verification
The bench builds the block with ADJ_CYCLES=6 and BUSY_CYCLES=8. These values keep the self-clearing adjust window and the busy window short enough to watch both the set and the cleared state within a couple of bus accesses. BUSY_CYCLES is also longer than one read, so busy can be seen high after a held tick and low again after idling. Directed sequences cover deferred ticks, the reset-gated 12/24 write and the chip-select override. A seeded random mix of external writes, reads and control writes is then checked against a bench model of location 15.

// File: rtl/rtc_bus_ctl.sv
module rtc_bus_ctl #(
  parameter int ADJ_CYCLES  = 16,
  parameter int BUSY_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ale,
  input  logic       cs0_n,
  input  logic       cs1,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [3:0] addr,
  input  logic [3:0] data_in,
  output logic [3:0] data_out,
  output logic       data_oe,
  input  logic       sec_tick,
  input  logic       fast_tick,
  input  logic       irq_flag,
  input  logic [2:0] sec10,
  input  logic [3:0] ext_rdata,
  output logic       ext_we,
  output logic [3:0] ext_addr,
  output logic [3:0] ext_wdata,
  output logic       flag_clr,
  output logic       sec_inc,
  output logic       adj_zero,
  output logic       adj_carry,
  output logic       div_clr,
  output logic       div_run,
  output logic       mode_24h
);
  localparam int AW = $clog2(ADJ_CYCLES + 1);
  localparam int BW = $clog2(BUSY_CYCLES + 1);
  localparam logic [3:0] LOC_CTL = 4'hD;
  localparam logic [3:0] LOC_CFG = 4'hF;

  logic [3:0]    addr_hold, eff_addr, rdata;
  logic          wr_q, hold_r, rest_r, stop_r, test_r, mode_r, pending;
  logic [AW-1:0] adj_cnt;
  logic [BW-1:0] busy_cnt;
  logic          sel, commit, tick_now, busy, adj_on;

  assign sel      = cs1 & ~cs0_n;
  assign eff_addr = (ale & ~cs0_n) ? addr : addr_hold;
  assign commit   = sel & wr_n & ~wr_q;
  assign tick_now = test_r ? fast_tick : (sec_tick & ~rest_r & ~stop_r);
  assign busy     = hold_r & (busy_cnt != '0);
  assign adj_on   = adj_cnt != '0;

  always_comb begin
    case (eff_addr)
      LOC_CTL: rdata = {adj_on, irq_flag, busy, hold_r};
      LOC_CFG: rdata = {test_r, mode_r, stop_r, rest_r};
      default: rdata = ext_rdata;
    endcase
  end

  assign data_oe  = sel & ~rd_n & wr_n;
  assign data_out = data_oe ? rdata : 4'h0;
  assign div_clr  = rest_r & ~test_r;
  assign div_run  = ~(stop_r & ~test_r);
  assign mode_24h = mode_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= 1'b1;
      addr_hold <= '0;
      ext_we <= 1'b0;
      ext_addr <= '0;
      ext_wdata <= '0;
      flag_clr <= 1'b0;
      adj_zero <= 1'b0;
      adj_carry <= 1'b0;
      adj_cnt <= '0;
      hold_r <= 1'b0;
      rest_r <= 1'b0;
      stop_r <= 1'b0;
      test_r <= 1'b0;
      mode_r <= 1'b0;
      pending <= 1'b0;
      sec_inc <= 1'b0;
      busy_cnt <= '0;
    end else begin
      wr_q <= wr_n;
      if (ale & ~cs0_n) addr_hold <= addr;

      ext_we    <= commit && eff_addr != LOC_CTL && eff_addr != LOC_CFG;
      ext_addr  <= eff_addr;
      ext_wdata <= data_in;
      flag_clr  <= 1'b0;
      adj_zero  <= 1'b0;
      adj_carry <= 1'b0;
      if (adj_on) adj_cnt <= adj_cnt - 1'b1;

      if (commit && eff_addr == LOC_CTL) begin
        hold_r   <= data_in[0];
        flag_clr <= ~data_in[2];
        if (data_in[3] && !adj_on) begin
          adj_cnt   <= AW'(ADJ_CYCLES);
          adj_zero  <= 1'b1;
          adj_carry <= sec10 >= 3'd3;
        end
      end
      if (commit && eff_addr == LOC_CFG) begin
        rest_r <= data_in[0];
        stop_r <= data_in[1];
        test_r <= data_in[3];
        if (rest_r) mode_r <= data_in[2];
      end
      if (!cs1) begin
        hold_r <= 1'b0;
        rest_r <= 1'b0;
      end

      sec_inc <= 1'b0;
      if (!hold_r && (tick_now || pending)) begin
        sec_inc <= 1'b1;
        pending <= 1'b0;
      end else if (hold_r && tick_now) begin
        pending <= 1'b1;
      end

      if (tick_now) busy_cnt <= BW'(BUSY_CYCLES);
      else if (busy_cnt != '0) busy_cnt <= busy_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/rtc_bus_ctl_chk.sv
module rtc_bus_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic cs1,
  input logic hold_r,
  input logic rest_r,
  input logic mode_r,
  input logic busy,
  input logic sec_inc,
  input logic adj_on,
  input logic adj_zero,
  input logic adj_carry
);
  assert_cs1_low_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cs1 |=> (!hold_r && !rest_r));

  assert_cs1_low_no_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cs1 |=> !busy);

  assert_no_inc_under_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sec_inc |-> !$past(hold_r));

  assert_mode_needs_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_r) |-> $past(rest_r));

  assert_adjust_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adj_on) |-> adj_zero);

  assert_carry_with_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    adj_carry |-> adj_zero);
endmodule

bind rtc_bus_ctl rtc_bus_ctl_chk u_chk (.*);

// File: tb/rtc_bus_ctl_test.sv
module rtc_bus_ctl_test;
  logic clk = 0, rst_n = 0;
  logic ale = 1, cs0_n = 1, cs1 = 1, rd_n = 1, wr_n = 1;
  logic [3:0] addr = 0, data_in = 0, ext_rdata = 0;
  logic sec_tick = 0, fast_tick = 0, irq_flag = 0;
  logic [2:0] sec10 = 0;
  logic [3:0] data_out, ext_addr, ext_wdata;
  logic data_oe, ext_we, flag_clr, sec_inc, adj_zero, adj_carry, div_clr, div_run, mode_24h;

  rtc_bus_ctl #(.ADJ_CYCLES(6), .BUSY_CYCLES(8)) uut (.*);

  always #4 clk = ~clk;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic w_we, w_fc, w_az, w_ac;
  logic [3:0] w_addr, w_data, r_data;
  logic r_oe, got;
  bit m_rest, m_stop, m_mode, m_test;

  function automatic logic [3:0] cfg_exp(bit rs, bit st, bit md, bit ts);
    return {ts, md, st, rs};
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [3:0] d, input bit use_ale, input bit c1);
    @(negedge clk);
    cs0_n = 0; cs1 = c1; addr = a; ale = 1;
    if (use_ale) begin @(negedge clk); ale = 0; addr = ~a; end
    data_in = d; wr_n = 0;
    @(negedge clk); wr_n = 1;
    @(negedge clk);
    w_we = ext_we; w_addr = ext_addr; w_data = ext_wdata;
    w_fc = flag_clr; w_az = adj_zero; w_ac = adj_carry;
    cs0_n = 1; cs1 = 1; ale = 1;
  endtask

  task automatic rd(input logic [3:0] a);
    @(negedge clk);
    cs0_n = 0; cs1 = 1; addr = a; ale = 1; rd_n = 0;
    #1; r_data = data_out; r_oe = data_oe;
    @(negedge clk); rd_n = 1; cs0_n = 1;
  endtask

  task automatic tick(input bit fast);
    @(negedge clk);
    if (fast) fast_tick = 1; else sec_tick = 1;
    @(negedge clk); got = sec_inc; sec_tick = 0; fast_tick = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk("R11 outputs", {data_oe, div_clr, div_run, mode_24h, sec_inc, ext_we}, 8'b001000);
    rd(4'hF); chk("R11 cfg", r_data, 4'h0);

    // R2 external write, latched address (R1) and pass-through
    wr(4'h5, 4'hA, 1, 1); chk("R1 latched addr", {w_we, w_addr, w_data}, {1'b1, 4'h5, 4'hA});
    wr(4'h3, 4'h6, 0, 1); chk("R2 pass-through write", {w_we, w_addr, w_data}, {1'b1, 4'h3, 4'h6});
    wr(4'h3, 4'h6, 0, 0); chk("R2 cs1 low write ignored", w_we, 1'b0);

    // R3 read enable
    ext_rdata = 4'h9; rd(4'h3); chk("R3 ext read", {r_oe, r_data}, {1'b1, 4'h9});
    @(negedge clk); cs0_n = 0; rd_n = 0; wr_n = 0; #1;
    chk("R3 rd+wr suppressed", {data_oe, data_out}, 5'h0);
    @(negedge clk); cs0_n = 1; wr_n = 1; rd_n = 1;
    @(negedge clk); cs1 = 0; cs0_n = 0; rd_n = 0; #1;
    chk("R3 cs1 low no drive", {data_oe, data_out}, 5'h0);
    @(negedge clk); cs1 = 1; cs0_n = 1; rd_n = 1;

    // R6 / R7 hold, busy, deferred tick
    wr(4'hD, 4'b0101, 1, 1);
    tick(0); chk("R6 held tick", got, 1'b0);
    rd(4'hD); chk("R7 busy under hold", r_data, 4'b0011);
    repeat (12) @(negedge clk);
    rd(4'hD); chk("R7 busy window ends", r_data, 4'b0001);
    wr(4'hD, 4'b0100, 0, 1);
    @(negedge clk); chk("R6 deferred pulse", sec_inc, 1'b1);
    @(negedge clk); chk("R6 single pulse", sec_inc, 1'b0);
    tick(0); chk("R6 free tick", got, 1'b1);
    rd(4'hD); chk("R7 busy low without hold", r_data[1], 1'b0);
    wr(4'hD, 4'b0110, 0, 1); rd(4'hD); chk("R7 busy not writable", r_data[1:0], 2'b00);

    // R5 cs1 override
    wr(4'hD, 4'b0101, 0, 1); wr(4'hF, 4'b0001, 0, 1);
    @(negedge clk); cs1 = 0; @(negedge clk); cs1 = 1;
    rd(4'hD); chk("R5 hold cleared", r_data[0], 1'b0);
    rd(4'hF); chk("R5 reset cleared", r_data[0], 1'b0);

    // R4 12/24 gated by reset
    wr(4'hF, 4'b0100, 0, 1); rd(4'hF); chk("R4 mode blocked", r_data, 4'b0000);
    wr(4'hF, 4'b0001, 1, 1); wr(4'hF, 4'b0101, 1, 1); rd(4'hF);
    chk("R4 mode set under reset", {r_data, mode_24h}, {4'b0101, 1'b1});
    wr(4'hF, 4'b0100, 0, 1); rd(4'hF); chk("R4 reset released", r_data, 4'b0100);

    // R9 stop, test, reset
    wr(4'hF, 4'b0110, 0, 1); chk("R9 stop div_run", div_run, 1'b0);
    tick(0); chk("R9 stop blocks tick", got, 1'b0);
    wr(4'hF, 4'b1110, 0, 1); chk("R9 test overrides stop", div_run, 1'b1);
    tick(1); chk("R9 fast tick in test", got, 1'b1);
    tick(0); chk("R9 slow tick ignored in test", got, 1'b0);
    wr(4'hF, 4'b1101, 0, 1); chk("R9 test masks div_clr", div_clr, 1'b0);
    tick(1); chk("R9 reset no block in test", got, 1'b1);
    wr(4'hF, 4'b0101, 0, 1); chk("R9 div_clr", div_clr, 1'b1);
    tick(0); chk("R9 reset blocks tick", got, 1'b0);
    wr(4'hF, 4'b0100, 0, 1);

    // R8 adjust
    sec10 = 3'd4; wr(4'hD, 4'b1100, 0, 1);
    chk("R8 adjust upper half", {w_az, w_ac}, 2'b11);
    rd(4'hD); chk("R8 adj bit set", r_data[3], 1'b1);
    repeat (10) @(negedge clk);
    rd(4'hD); chk("R8 adj bit self-clears", r_data[3], 1'b0);
    sec10 = 3'd2; wr(4'hD, 4'b1100, 0, 1);
    chk("R8 adjust lower half", {w_az, w_ac}, 2'b10);
    repeat (10) @(negedge clk);

    // R10 flag
    chk("R10 no clear with bit2=1", w_fc, 1'b0);
    wr(4'hD, 4'b0000, 0, 1); chk("R10 clear pulse", w_fc, 1'b1);
    irq_flag = 1; rd(4'hD); chk("R10 flag readback", r_data[2], 1'b1);
    irq_flag = 0;

    // random mix
    m_rest = 0; m_stop = 0; m_mode = 1; m_test = 0;
    for (int i = 0; i < 60; i++) begin
      int op = $urandom_range(0, 2);
      logic [3:0] a = 4'($urandom_range(0, 13));
      logic [3:0] d = 4'($urandom);
      bit la = 1'($urandom);
      if (a == 4'hD) a = 4'hE;
      if (op == 0) begin
        wr(a, d, la, 1);
        chk("R2 random ext write", {w_we, w_addr, w_data}, {1'b1, a, d});
      end else if (op == 1) begin
        wr(4'hF, d, la, 1);
        if (m_rest) m_mode = d[2];
        m_rest = d[0]; m_stop = d[1]; m_test = d[3];
        rd(4'hF);
        chk("R4 random cfg", r_data, cfg_exp(m_rest, m_stop, m_mode, m_test));
      end else begin
        ext_rdata = d; rd(a);
        chk("R3 random read", {r_oe, r_data}, {1'b1, d});
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule